// File: doc/BRIEF.md
# Stepped Power-Down Clock Post-Divider

This block sits after a fast oscillator clock and produces a divided square-wave output. A 2-bit ratio code selects division by 1, 2, 4 or 8, and the output keeps a 50% duty cycle at every ratio. The block input `clkIn` runs at twice the oscillator rate. Because of that, every ratio, divide-by-1 included, comes out of a plain registered toggle and no clock gating is needed. The output half-period is 2^code cycles of `clkIn`, and the full period is 2^(code+1) cycles.

A power-down request adds a further division by 16. That factor is not applied in one jump. A step index in a slower reference-clock domain walks through extra factors of 1, 2, 4, 8 and 16, one step per reference edge. It moves up while power-down is requested and back down after release, so the output frequency falls and recovers in four discrete steps.

The step index crosses into the fast domain as a Gray code. A new ratio is taken up only at the start of an output period, so no period is ever cut short. An output-enable input parks the output low after the current high phase. When it is raised again, the output restarts with a full low phase.

Top module: `stepped_postdiv`

## Requirements
- R1: With no extra division, ratio code n (0..3) gives an output high phase of 2^n `clkIn` cycles and a period of 2^(n+1) cycles.
- R2: Every complete output period has equal high and low phase lengths.
- R3: While `pwrDown` is high, the first two reference edges are spent on synchronization. Each later reference edge doubles the extra division, so the high phase becomes 2^(n+s) cycles at step s.
- R4: Once the extra division reaches 16 (step 4), further reference edges with `pwrDown` high leave the output period unchanged.
- R5: After `pwrDown` falls, two reference edges pass with no change. Each later edge halves the extra division, reaching the programmed ratio after four steps.
- R6: The step index changes by at most one per reference edge, so the measured period never reverses direction within a ramp.
- R7: A ratio change takes effect only at an output rising edge. Every period measured across a change is complete (high equals low) and uses either the old ratio or the new one.
- R8: When `outEn` falls during a high phase, that high phase still runs its full length, and the output then stays low.
- R9: When `outEn` rises again, the output leaves the low state and its first high phase has the full programmed length.
- R10: While `rstN` is low, `clkOut` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIn | input | 1 | Fast clock, twice the oscillator rate |
| refClk | input | 1 | Slow reference clock that paces the power-down steps |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| nCode | input | 2 | Ratio code: half-period = 2^nCode `clkIn` cycles |
| pwrDown | input | 1 | Requests the extra divide-by-16 |
| outEn | input | 1 | Output enable; low parks `clkOut` low |
| clkOut | output | 1 | Divided output clock |

## Verification
A wrong step index or a corrupted Gray transfer appears at the port as an output period that is off by a power of two. The error shows within one or two output periods of the reference edge that caused it. A ratio loaded in mid-period appears at once as a period whose high and low lengths differ. A broken enable path appears as a shortened high phase, or as a rising edge while the output should be parked low. The bench measures phase lengths at the pin after every reference step and across one ratio change, so each of these faults appears in the very next measured period.

// File: rtl/spd_pkg.sv
package spd_pkg;
  localparam int CODE_W    = 2;
  localparam int MAX_STEP  = 4;
  localparam int STEP_W    = $clog2(MAX_STEP + 1);
  localparam int MAX_SHIFT = (2 ** CODE_W - 1) + MAX_STEP;
  localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);
  localparam int CNT_W     = MAX_SHIFT;

  // Strobes handed from control to datapath in the fast domain.
  typedef struct packed {
    logic               run;
    logic [SHIFT_W-1:0] shift;
  } divCtl_t;

  function automatic logic [STEP_W-1:0] toGray(input logic [STEP_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [STEP_W-1:0] fromGray(input logic [STEP_W-1:0] g);
    logic [STEP_W-1:0] b;
    b[STEP_W-1] = g[STEP_W-1];
    for (int i = STEP_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/spd_ctrl.sv
module spd_ctrl
  import spd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              refClk,
  input  logic              clkIn,
  input  logic              rstN,
  input  logic              pwrDown,
  input  logic              outEn,
  input  logic [CODE_W-1:0] nCode,
  output divCtl_t           ctl,
  output logic [STEP_W-1:0] stepRef,
  output logic [STEP_W-1:0] grayVco
);
  localparam int LAST = SYNC_STAGES - 1;

  // reference domain: power-down synchronizer and step walker
  logic [SYNC_STAGES-1:0] pdPipe;
  logic                   pdSeen;
  logic [STEP_W-1:0]      stepNext;
  logic [STEP_W-1:0]      grayRef;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) pdPipe <= '0;
    else       pdPipe <= {pdPipe[LAST-1:0], pwrDown};
  end

  assign pdSeen = pdPipe[LAST];

  always_comb begin
    stepNext = stepRef;
    if (pdSeen && stepRef != STEP_W'(MAX_STEP))
      stepNext = stepRef + STEP_W'(1);
    else if (!pdSeen && stepRef != '0)
      stepNext = stepRef - STEP_W'(1);
  end

  // The Gray copy is a flop output, so the crossing sees one bit move per step.
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      stepRef <= '0;
      grayRef <= '0;
    end else begin
      stepRef <= stepNext;
      grayRef <= toGray(stepNext);
    end
  end

  // fast domain: synchronizers and ratio sum
  logic [STEP_W-1:0]      grayPipe [SYNC_STAGES];
  logic [SYNC_STAGES-1:0] oePipe;
  logic [CODE_W-1:0]      codeReg;
  logic [STEP_W-1:0]      stepVco;

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) grayPipe[i] <= '0;
      oePipe  <= '0;
      codeReg <= '0;
      stepVco <= '0;
      ctl     <= '0;
    end else begin
      grayPipe[0] <= grayRef;
      for (int i = 1; i < SYNC_STAGES; i++) grayPipe[i] <= grayPipe[i-1];
      oePipe    <= {oePipe[LAST-1:0], outEn};
      codeReg   <= nCode;
      stepVco   <= fromGray(grayPipe[LAST]);
      ctl.run   <= oePipe[LAST];
      ctl.shift <= SHIFT_W'(codeReg) + SHIFT_W'(stepVco);
    end
  end

  assign grayVco = grayPipe[LAST];
endmodule

// File: rtl/spd_core.sv
module spd_core
  import spd_pkg::*;
(
  input  logic               clkIn,
  input  logic               rstN,
  input  divCtl_t            ctl,
  output logic               clkOut,
  output logic [SHIFT_W-1:0] actShift
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] lastCnt;
  logic             phaseEnd;
  logic             outQ;

  assign span     = (CNT_W + 1)'(1) << actShift;
  assign lastCnt  = CNT_W'(span - (CNT_W + 1)'(1));
  assign phaseEnd = (cnt == lastCnt);

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      outQ     <= 1'b0;
      actShift <= '0;
    end else if (outQ) begin
      // a high phase always runs to its end
      if (phaseEnd) begin
        outQ <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end else if (!ctl.run) begin
      cnt <= '0;
    end else if (phaseEnd) begin
      // period boundary: the only place a new ratio is taken up
      outQ     <= 1'b1;
      cnt      <= '0;
      actShift <= ctl.shift;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign clkOut = outQ;
endmodule

// File: rtl/stepped_postdiv.sv
module stepped_postdiv
  import spd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clkIn,
  input  logic              refClk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] nCode,
  input  logic              pwrDown,
  input  logic              outEn,
  output logic              clkOut
);
  divCtl_t            ctl;
  logic [STEP_W-1:0]  stepRef;
  logic [STEP_W-1:0]  grayVco;
  logic [SHIFT_W-1:0] actShift;

  spd_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .refClk (refClk),
    .clkIn  (clkIn),
    .rstN   (rstN),
    .pwrDown(pwrDown),
    .outEn  (outEn),
    .nCode  (nCode),
    .ctl    (ctl),
    .stepRef(stepRef),
    .grayVco(grayVco)
  );

  spd_core u_core (
    .clkIn   (clkIn),
    .rstN    (rstN),
    .ctl     (ctl),
    .clkOut  (clkOut),
    .actShift(actShift)
  );
endmodule

// File: rtl/spd_chk.sv
module spd_chk
  import spd_pkg::*;
(
  input logic               clkIn,
  input logic               refClk,
  input logic               rstN,
  input logic               clkOut,
  input logic               run,
  input logic [SHIFT_W-1:0] actShift,
  input logic [STEP_W-1:0]  stepRef,
  input logic [STEP_W-1:0]  grayVco
);
  // R6: the step index moves by at most one per reference edge
  a_r6_single_step: assert property (@(posedge refClk) disable iff (!rstN)
    (stepRef != $past(stepRef)) |->
      ((stepRef == $past(stepRef) + STEP_W'(1)) || (stepRef + STEP_W'(1) == $past(stepRef))));

  // R4: the step index never goes past divide-by-16
  a_r4_step_bounded: assert property (@(posedge refClk) disable iff (!rstN)
    stepRef <= STEP_W'(MAX_STEP));

  // R6: the synchronized Gray code flips at most one bit per fast cycle
  a_r6_gray_one_bit: assert property (@(posedge clkIn) disable iff (!rstN)
    $countones(grayVco ^ $past(grayVco)) <= 1);

  // R7: the active ratio changes only together with an output rising edge
  a_r7_ratio_at_rise: assert property (@(posedge clkIn) disable iff (!rstN)
    !$rose(clkOut) |-> $stable(actShift));

  // R8: no rising edge while the enable strobe is low
  a_r8_rise_needs_run: assert property (@(posedge clkIn) disable iff (!rstN)
    $rose(clkOut) |-> $past(run));
endmodule

bind stepped_postdiv spd_chk u_chk (
  .clkIn   (clkIn),
  .refClk  (refClk),
  .rstN    (rstN),
  .clkOut  (clkOut),
  .run     (ctl.run),
  .actShift(actShift),
  .stepRef (stepRef),
  .grayVco (grayVco)
);

// File: tb/stepped_postdiv_tb.sv
module stepped_postdiv_tb;
  logic       clkIn = 1'b0;
  logic       refClk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] nCode = 2'd0;
  logic       pwrDown = 1'b0;
  logic       outEn = 1'b1;
  logic       clkOut;

  int nChecks = 0;
  int nBad = 0;
  int expQ[$];
  string tagQ[$];
  int hiLog[$];

  always #4 clkIn = ~clkIn;

  stepped_postdiv u_dut (
    .clkIn(clkIn), .refClk(refClk), .rstN(rstN), .nCode(nCode),
    .pwrDown(pwrDown), .outEn(outEn), .clkOut(clkOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitRise();
    logic p;
    do begin
      p = clkOut;
      @(negedge clkIn);
    end while (!(clkOut && !p));
  endtask

  // call right after a rise was seen; returns at the next rise
  task automatic measureOnce(output int hi, output int per);
    logic p;
    hi = 1; per = 1; p = 1'b1;
    forever begin
      @(negedge clkIn);
      if (clkOut && !p) break;
      per++;
      if (clkOut) hi++;
      p = clkOut;
    end
  endtask

  task automatic refPulse();
    #20 refClk = 1'b1;
    #40 refClk = 1'b0;
    #20;
  endtask

  task automatic expectHalf(input int half, input string tag);
    expQ.push_back(half);
    tagQ.push_back(tag);
    wait (expQ.size() == 0);
  endtask

  // monitor: pops an expected half-period and checks a settled period
  initial begin
    forever begin
      int e, hi, per;
      string t;
      wait (expQ.size() != 0);
      e = expQ[0];
      t = tagQ[0];
      waitRise(); waitRise(); waitRise();
      measureOnce(hi, per);
      check(hi == e, {t, " high phase"}, hi, e);
      check(per == 2 * hi, "R2 duty", per - hi, hi);
      hiLog.push_back(hi);
      void'(tagQ.pop_front());
      void'(expQ.pop_front());
    end
  end

  initial begin
    repeat (150000) @(posedge clkIn);
    nBad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    int hi, per;
    repeat (6) @(negedge clkIn);
    check(clkOut == 1'b0, "R10 reset output", int'(clkOut), 0);
    rstN = 1'b1;

    // R1: each ratio code without power-down
    for (int c = 0; c < 4; c++) begin
      nCode = 2'(c);
      expectHalf(1 << c, "R1");
    end

    // R3: ramp toward divide-by-16 with code 1
    nCode = 2'd1;
    expectHalf(2, "R1");
    pwrDown = 1'b1;
    refPulse(); refPulse();
    expectHalf(2, "R3 sync delay");
    hiLog.delete();
    for (int s = 1; s <= 4; s++) begin
      refPulse();
      if (s == 2) begin
        // R7: periods straddling a ratio change stay whole
        waitRise();
        for (int k = 0; k < 3; k++) begin
          measureOnce(hi, per);
          check(per == 2 * hi && (hi == 4 || hi == 8), "R7 whole period", hi, 8);
        end
      end
      expectHalf(2 << s, "R3");
    end
    for (int k = 1; k < hiLog.size(); k++)
      check(hiLog[k] > hiLog[k-1], "R6 ramp up monotonic", hiLog[k], hiLog[k-1]);

    // R4: saturation
    refPulse(); refPulse();
    expectHalf(32, "R4");

    // R5: release and ramp back
    pwrDown = 1'b0;
    refPulse(); refPulse();
    expectHalf(32, "R5 sync delay");
    hiLog.delete();
    for (int s = 3; s >= 0; s--) begin
      refPulse();
      expectHalf(2 << s, "R5");
    end
    for (int k = 1; k < hiLog.size(); k++)
      check(hiLog[k] < hiLog[k-1], "R6 ramp down monotonic", hiLog[k], hiLog[k-1]);

    // R8: disable during a high phase
    nCode = 2'd2;
    expectHalf(4, "R1");
    waitRise();
    outEn = 1'b0;
    hi = 1;
    forever begin
      @(negedge clkIn);
      if (!clkOut) break;
      hi++;
    end
    check(hi == 4, "R8 high phase completes", hi, 4);
    per = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clkIn);
      if (clkOut) per++;
    end
    check(per == 0, "R8 parked low", per, 0);

    // R9: re-enable
    outEn = 1'b1;
    waitRise();
    measureOnce(hi, per);
    check(hi == 4, "R9 first high phase", hi, 4);
    check(per == 8, "R9 first period", per, 8);

    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule